// File: doc/BRIEF.md
# PWM Clock-Enable Generator

This block supplies the timing references for a multi-channel PWM controller. A free-running binary prescaler turns the single PWM base clock into eleven rates: the base clock itself and the base clock divided by 2, 4, 8, 16, 32, 64, 128, 256, 512 and 1024. Two programmable linear dividers, A and B, each take one of those eleven rates and divide it again by an integer from 1 to 255. Divider A and divider B are independent of each other.

Every output is a one-cycle clock-enable pulse in the base clock domain, not a derived clock. A per-channel selector lets each PWM channel choose one of the thirteen enables, or none at all. Configuration arrives on a simple single-cycle write port. A divide value of zero switches a divider off, and reset leaves both dividers off.

Top module: `pwm_clkgen`

## Requirements
- R1: The base-rate enable (`tap_en[0]`) is high in every cycle, including while reset is held.
- R2: For k from 1 to 10, `tap_en[k]` is a one-cycle pulse that repeats every 2^k cycles. Each pulse of tap k coincides with a pulse of tap k-1.
- R3: While reset is held, `tap_en[10:1]` are all low. After the first clock edge with reset released, all eleven taps pulse together in the same cycle. In the cycle after that, only `tap_en[0]` is high.
- R4: A divider with divide value N (1..255) and input select k (0..10) produces a one-cycle pulse every N*2^k cycles. Each output pulse coincides with a pulse of its selected tap.
- R5: A divider whose divide value is 0 produces no pulses. Reset clears both divide values and both input selects to 0, so `clk_a_en` and `clk_b_en` stay low after reset.
- R6: Writing a divider's configuration restarts its count. Its first output pulse after the write coincides with the N-th pulse of the selected tap that arrives after the write edge.
- R7: With divide value 1 and input select 0, the divider output is high in every cycle.
- R8: Each channel has a 4-bit source code. Codes 0..10 select `tap_en[code]`, code 11 selects clock A, code 12 selects clock B, and codes 13..15 give a constantly low enable. Reset sets every channel code to 0.
- R9: Write address 0 configures divider A and address 1 configures divider B, with `wr_data[7:0]` as the divide value and `wr_data[11:8]` as the input select. A divider input select of 11..15 selects no input, so that divider never pulses. Address 2+c sets channel c's code from `wr_data[3:0]`. A written value takes effect in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe, one cycle per write |
| wr_addr | input | 4 | Configuration write address |
| wr_data | input | 12 | Configuration write data |
| tap_en | output | 11 | Prescaler enables, bit k pulses at base/2^k |
| clk_a_en | output | 1 | Divider A enable pulse |
| clk_b_en | output | 1 | Divider B enable pulse |
| ch_en | output | 4 | Selected enable for each PWM channel |

## Verification
The prescaler taps and every configuration register sit one register from their cause. A tap pattern or a written value therefore shows up in the first cycle after the edge that updates it, while the divider and channel outputs follow that register state combinationally in the same cycle. The bench drives writes on a falling edge and begins observing at the next falling edge, so the first sample already reflects the write edge. Periods are taken as the distance between two consecutive observed pulses, which makes them independent of the prescaler phase. The restart check counts selected-tap pulses starting from that same first sample.

// File: rtl/pwm_clkgen_pkg.sv
// Package: shared constants for the PWM clock-enable generator.
// Holds the default geometry and the write-port address map.
package pwm_clkgen_pkg;
    localparam int DEF_TAPS    = 11;   // prescaler rates: /1 .. /1024
    localparam int DEF_DIV_W   = 8;    // linear divide value width
    localparam int DEF_SEL_W   = 4;    // source-select code width
    localparam int DEF_NUM_CH  = 4;    // PWM channels served
    localparam int DEF_ADDR_W  = 4;    // write address width

    localparam int ADDR_DIV_A  = 0;    // divider A configuration
    localparam int ADDR_DIV_B  = 1;    // divider B configuration
    localparam int ADDR_CH_0   = 2;    // first channel code register
    localparam int NUM_DIV     = 2;    // linear dividers A and B
endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Free-running binary prescaler. Output k pulses for one cycle every 2^k
// cycles; output 0 is always high. Assumes TAPS >= 2. While reset is held,
// only output 0 is active. The counter starts one edge after release, so
// all taps pulse together in the first cycle after that edge.
module pwm_prescaler #(
    parameter int TAPS = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tap_en
);
    localparam int CW = TAPS - 1;

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Count base cycles once the prescaler is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (run_q) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode each tap from the low bits of the counter wrapping to zero.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_base
            assign tap_en[0] = 1'b1;
        end else begin : g_div
            assign tap_en[k] = run_q && (cnt_q[k-1:0] == '0);
            // R2: taps nest, each pulse of tap k lies on a pulse of tap k-1
            a_r2_taps_nest: assert property (@(posedge clk) disable iff (!rst_n)
                tap_en[k] |-> tap_en[k-1]);
        end
    end

    // R2: the divide-by-2 tap never stays high two cycles in a row
    a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[1] |=> !tap_en[1]);
endmodule

// File: rtl/pwm_lindiv.sv
// Module: pwm_lindiv
// Linear divider. It counts pulses of one selected prescaler tap and
// emits a pulse on every DIV-th one. A divide value of zero disables the
// output. A select code at or above TAPS selects no input. The restart
// input must be raised in the cycle that the divide or select value is
// rewritten, so the count starts again from zero.
module pwm_lindiv #(
    parameter int TAPS  = 11,
    parameter int DIV_W = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAPS-1:0]  tap_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt_q;
    logic             in_pulse;
    logic             at_last;
    logic             active;

    // Pick the selected tap; out-of-range codes give no input.
    always_comb begin
        in_pulse = 1'b0;
        for (int i = 0; i < TAPS; i++) begin
            if (sel == SEL_W'(i)) in_pulse = tap_en[i];
        end
    end

    // Decode the terminal count and the enabled state.
    always_comb begin
        active = (div != '0);
        at_last = (cnt_q == div - DIV_W'(1));
        pulse = active && in_pulse && at_last;
    end

    // Advance the count on each selected input pulse, wrapping at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (active && in_pulse) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R6: a configuration write leaves the count at zero
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R4: with a ratio of two or more, output pulses are never adjacent
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && (div > DIV_W'(1)) && !restart) |=> !pulse);
    // R4: the count stays below the divide value while enabled
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < div));
endmodule

// File: rtl/pwm_src_mux.sv
// Module: pwm_src_mux
// Per-channel source selector. The code picks one of NSRC enables;
// codes at or above NSRC yield a constantly low enable. Purely
// combinational, so it assumes a registered code.
module pwm_src_mux #(
    parameter int NSRC  = 13,
    parameter int SEL_W = 4
) (
    input  logic [NSRC-1:0]  src_en,
    input  logic [SEL_W-1:0] code,
    output logic             en
);
    // Compare the code against every source index.
    always_comb begin
        en = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (code == SEL_W'(i)) en = src_en[i];
        end
    end
endmodule

// File: rtl/pwm_clkgen.sv
// Module: pwm_clkgen (top)
// PWM clock-enable generator. It combines a binary prescaler, two linear
// dividers (A and B), per-channel source selectors and the configuration
// registers behind a single-cycle write port. All outputs are one-cycle
// enables in the clk domain. Assumes NUM_CH + ADDR_CH_0 fits in ADDR_W.
module pwm_clkgen
    import pwm_clkgen_pkg::*;
#(
    parameter int TAPS   = DEF_TAPS,
    parameter int DIV_W  = DEF_DIV_W,
    parameter int SEL_W  = DEF_SEL_W,
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DIV_W+SEL_W-1:0]   wr_data,
    output logic [TAPS-1:0]          tap_en,
    output logic                     clk_a_en,
    output logic                     clk_b_en,
    output logic [NUM_CH-1:0]        ch_en
);
    localparam int NSRC  = TAPS + NUM_DIV;
    localparam int CODE_A = TAPS;
    localparam int CODE_B = TAPS + 1;

    logic [DIV_W-1:0] div_q  [NUM_DIV];
    logic [SEL_W-1:0] dsel_q [NUM_DIV];
    logic [NUM_DIV-1:0] div_wr;
    logic [NUM_DIV-1:0] lin_pulse;
    logic [SEL_W-1:0] code_q [NUM_CH];
    logic [NSRC-1:0]  src_en;

    pwm_prescaler #(.TAPS(TAPS)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_en (tap_en)
    );

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        // Strobe that rewrites this divider's configuration.
        assign div_wr[d] = wr_en && (wr_addr == ADDR_W'(ADDR_DIV_A + d));

        // Hold the divide value and input select of this divider.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                div_q[d]  <= '0;
                dsel_q[d] <= '0;
            end else if (div_wr[d]) begin
                div_q[d]  <= wr_data[DIV_W-1:0];
                dsel_q[d] <= wr_data[DIV_W +: SEL_W];
            end
        end

        pwm_lindiv #(.TAPS(TAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_lindiv (
            .clk     (clk),
            .rst_n   (rst_n),
            .tap_en  (tap_en),
            .sel     (dsel_q[d]),
            .div     (div_q[d]),
            .restart (div_wr[d]),
            .pulse   (lin_pulse[d])
        );

        // R5: a divider at ratio zero stays silent
        a_r5_zero_is_off: assert property (@(posedge clk) disable iff (!rst_n)
            (div_q[d] == '0) |-> !lin_pulse[d]);
    end

    assign clk_a_en = lin_pulse[ADDR_DIV_A];
    assign clk_b_en = lin_pulse[ADDR_DIV_B];
    assign src_en   = {clk_b_en, clk_a_en, tap_en};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Hold this channel's source code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[c] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(ADDR_CH_0 + c))) begin
                code_q[c] <= wr_data[SEL_W-1:0];
            end
        end

        pwm_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
            .src_en (src_en),
            .code   (code_q[c]),
            .en     (ch_en[c])
        );

        // R9: a channel write lands in the next cycle
        a_r9_code_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == ADDR_W'(ADDR_CH_0 + c)))
            |=> (code_q[c] == $past(wr_data[SEL_W-1:0])));
        // R8: unused codes give no enable
        a_r8_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q[c] > SEL_W'(CODE_B)) |-> !ch_en[c]);
        // R8: code for clock A forwards divider A
        a_r8_follow_a: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q[c] == SEL_W'(CODE_A)) |-> (ch_en[c] == clk_a_en));
        // R8: code for clock B forwards divider B
        a_r8_follow_b: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q[c] == SEL_W'(CODE_B)) |-> (ch_en[c] == clk_b_en));
    end
endmodule

// File: tb/pwm_clkgen_bench.sv
// Directed bench for pwm_clkgen: one task per scenario, each checking itself.
module pwm_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [10:0] tap_en;
    logic        clk_a_en;
    logic        clk_b_en;
    logic [3:0]  ch_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_clkgen u_pwm_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tap_en   (tap_en),
        .clk_a_en (clk_a_en),
        .clk_b_en (clk_b_en),
        .ch_en    (ch_en)
    );

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Observed signal by index: 0..10 taps, 11 A, 12 B, 13+c channel c.
    function automatic logic sig(int idx);
        if (idx < 11) return tap_en[idx];
        if (idx == 11) return clk_a_en;
        if (idx == 12) return clk_b_en;
        return ch_en[idx-13];
    endfunction

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 12'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Distance between two consecutive pulses and width of the first one.
    task automatic measure(int idx, int limit, output int period, output int width);
        int n = 0;
        period = -1;
        width = 0;
        while (!sig(idx) && n < limit) begin @(negedge clk); n++; end
        if (n >= limit) return;
        while (sig(idx) && width < limit) begin @(negedge clk); width++; end
        period = width;
        while (!sig(idx) && period < limit) begin @(negedge clk); period++; end
        if (period >= limit) period = -1;
    endtask

    // Number of pulses of a signal over a window.
    task automatic count_pulses(int idx, int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(idx)) cnt++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "base tap in reset", int'(tap_en[0]), 1);
        check("R3", "taps in reset", int'(tap_en), 1);
        check("R5", "clk A/B in reset", int'({clk_a_en, clk_b_en}), 0);
        check("R8", "channels default to base rate", int'(ch_en), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", "all taps after first edge", int'(tap_en), 2047);
        @(negedge clk);
        check("R3", "only base tap next cycle", int'(tap_en), 1);
    endtask

    task automatic t_taps();
        int p, w, c;
        count_pulses(0, 50, c);
        check("R1", "base tap every cycle", c, 50);
        for (int k = 1; k < 11; k += 3) begin
            measure(k, 3000, p, w);
            check("R2", $sformatf("tap %0d period", k), p, 1 << k);
            check("R2", $sformatf("tap %0d width", k), w, 1);
        end
    endtask

    task automatic t_div_off();
        int c;
        count_pulses(11, 300, c);
        check("R5", "clk A off after reset", c, 0);
        wr(1, 12'h000);
        count_pulses(12, 300, c);
        check("R5", "clk B with ratio 0", c, 0);
    endtask

    task automatic t_div_every();
        int c;
        wr(0, 12'h001);
        count_pulses(11, 40, c);
        check("R7", "ratio 1 on base tap", c, 40);
    endtask

    task automatic t_div_periods();
        int p, w;
        wr(0, 12'h305);
        measure(11, 500, p, w);
        check("R4", "A = tap3 / 5 period", p, 40);
        check("R4", "A pulse width", w, 1);
        wr(0, 12'h0FF);
        measure(11, 1000, p, w);
        check("R4", "A = base / 255 period", p, 255);
        wr(1, 12'hA02);
        measure(12, 7000, p, w);
        check("R4", "B = tap10 / 2 period", p, 2048);
    endtask

    task automatic t_restart();
        int seen = 0, got = -1, both = 0;
        wr(0, 12'h10A);
        repeat (5) @(negedge clk);
        wr(0, 12'h103);
        for (int i = 0; i < 30; i++) begin
            if (tap_en[1]) seen++;
            if (clk_a_en) begin got = seen; both = int'(tap_en[1]); break; end
            @(negedge clk);
        end
        check("R6", "tap pulses to first output", got, 3);
        check("R6", "output on tap pulse", both, 1);
    endtask

    task automatic t_channels();
        int p, w, miss;
        wr(0, 12'h204);     // A = tap2 / 4  -> period 16
        wr(1, 12'h103);     // B = tap1 / 3  -> period 6
        wr(2, 11);
        wr(3, 12);
        wr(4, 13);
        wr(5, 5);
        miss = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (ch_en[0] != clk_a_en) miss++;
            if (ch_en[1] != clk_b_en) miss++;
            if (ch_en[2]) miss++;
        end
        check("R8", "ch0/ch1 follow A/B, ch2 code 13 silent", miss, 0);
        measure(16, 200, p, w);
        check("R8", "ch3 code 5 period", p, 32);
        measure(13, 200, p, w);
        check("R8", "ch0 carries A period", p, 16);
        wr(4, 15);
        count_pulses(15, 100, miss);
        check("R8", "code 15 silent", miss, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd4; wr_data = 12'd0;
        check("R9", "ch2 before write edge", int'(ch_en[2]), 0);
        @(negedge clk);
        wr_en = 1'b0;
        check("R9", "ch2 in cycle after write", int'(ch_en[2]), 1);
    endtask

    task automatic t_bad_sel();
        int c;
        wr(1, 12'hC01);
        count_pulses(12, 300, c);
        check("R9", "divider select 12 gives no input", c, 0);
        wr(0, 12'hF01);
        count_pulses(11, 300, c);
        check("R9", "divider select 15 gives no input", c, 0);
    endtask

    initial begin
        t_reset();
        t_taps();
        t_div_off();
        t_div_every();
        t_div_periods();
        t_restart();
        t_channels();
        t_bad_sel();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        summary();
        $finish;
    end
endmodule